// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block watches the two rising-edge streams that feed a phase-frequency detector, the reference and the divided feedback, and tells whether the loop has settled. Both inputs are retimed into a fast sampling clock. The block counts the ticks of that clock between the two rising edges of each comparison cycle and does not care which input arrives first. It then sorts each measurement into one of three classes: good, neutral or bad.

Lock is raised only after a programmable run of good cycles in a row. Once lock is up, it drops on the first bad cycle. A gap between the narrow lock window and the wider unlock window gives hysteresis, so a phase error that is a little too large does not make the indicator chatter. A select input picks one of two window pairs. If the second edge of a cycle never arrives, a timeout ends the cycle and counts it as bad. The comparison period must be longer than the unlock window.

The skew meter state machine has three states. `MS_IDLE` waits for the first edge. It moves to `MS_WAIT_FB` when the reference rises alone and to `MS_WAIT_REF` when the feedback rises alone. If both rise together, it stays in `MS_IDLE` and reports a skew of zero. Each wait state goes back to `MS_IDLE` when the missing edge arrives (a measured result) or when the tick count reaches the timeout (a timeout result). The lock state machine has two states. `LS_HUNT` counts good results; any other result clears the count, and reaching the target takes it to `LS_LOCKED`. `LS_LOCKED` goes back to `LS_HUNT` on a bad result.

Top module: `pll_lock_watch`

## Requirements
- R1: Reset drives `lock_o` low and clears the run of good cycles, so after reset a full run is needed again.
- R2: The skew is the number of fast-clock ticks between the two rising edges, whichever input leads. Edges in the same tick give a skew of zero.
- R3: While unlocked, `lock_o` rises after the Nth consecutive good cycle and not after N-1. A cycle is good when its skew is strictly less than the active lock threshold.
- R4: `cnt_sel` sets N: 0 gives 5, 1 gives 16, 2 gives 64, 3 gives 255.
- R5: While unlocked, a cycle whose skew is equal to or greater than the lock threshold, or that times out, clears the run to zero.
- R6: While locked, a cycle whose skew is at least the lock threshold and at most the unlock threshold leaves `lock_o` high.
- R7: While locked, a single cycle whose skew is greater than the unlock threshold drops `lock_o`.
- R8: `win_sel` = 0 selects lock/unlock thresholds of 4/8 ticks and `win_sel` = 1 selects 8/16 ticks (default parameters).
- R9: If the second edge has not arrived within 40 ticks (`TIMEOUT_TICKS`) of the first, the cycle is counted as exceeding the unlock threshold.
- R10: `lock_o` changes only in the cycle after a measurement completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference input to the phase detector (asynchronous) |
| fb_in | input | 1 | Feedback input to the phase detector (asynchronous) |
| win_sel | input | 1 | Window pair select: 0 narrow, 1 wide |
| cnt_sel | input | 2 | Consecutive-good-cycle count select |
| lock_o | output | 1 | Lock indicator |

## Verification
Directed runs place the skew exactly on each threshold: one tick below the lock threshold, equal to it, equal to the unlock threshold, and one tick above it. These runs separate strict from inclusive comparisons and confirm that the neutral band neither sets nor clears lock. Runs of N-1 and N good cycles for each count setting expose off-by-one errors in the run counter. A run broken by a single borderline cycle, or restarted by reset, shows whether the counter is cleared. Constrained random cycles vary the lead input, the skew, the window pair and missing edges against a reference model in the bench. They test symmetry between the two inputs and the timeout path.

// File: rtl/pll_lockdet_pkg.sv
package pll_lockdet_pkg;

    localparam int RUN_W = 8;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_WAIT_FB,
        MS_WAIT_REF
    } meas_state_t;

    typedef enum logic {
        LS_HUNT,
        LS_LOCKED
    } lock_state_t;

    // Number of consecutive good cycles needed for each count setting
    function automatic logic [RUN_W-1:0] run_target(input logic [1:0] sel);
        logic [RUN_W-1:0] t;
        unique case (sel)
            2'd0: t = RUN_W'(5);
            2'd1: t = RUN_W'(16);
            2'd2: t = RUN_W'(64);
            default: t = RUN_W'(255);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/skew_meter.sv
module skew_meter
    import pll_lockdet_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 40,
    parameter int MW            = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_rise,
    input  logic          fb_rise,
    output logic          meas_valid,
    output logic [MW-1:0] meas_ticks,
    output logic          meas_timeout
);
    localparam logic [MW-1:0] TO_LIM = MW'(TIMEOUT_TICKS);
    localparam logic [MW-1:0] ONE    = MW'(1);

    meas_state_t   st_q, st_n;
    logic [MW-1:0] tick_q, tick_n;
    logic          val_n, tmo_n;
    logic [MW-1:0] res_n;

    always_comb begin
        st_n   = st_q;
        tick_n = tick_q;
        val_n  = 1'b0;
        tmo_n  = 1'b0;
        res_n  = meas_ticks;
        unique case (st_q)
            MS_IDLE: begin
                if (ref_rise && fb_rise) begin
                    val_n = 1'b1;
                    res_n = '0;
                end else if (ref_rise) begin
                    st_n   = MS_WAIT_FB;
                    tick_n = ONE;
                end else if (fb_rise) begin
                    st_n   = MS_WAIT_REF;
                    tick_n = ONE;
                end
            end
            MS_WAIT_FB, MS_WAIT_REF: begin
                if ((st_q == MS_WAIT_FB) ? fb_rise : ref_rise) begin
                    val_n = 1'b1;
                    res_n = tick_q;
                    st_n  = MS_IDLE;
                end else if (tick_q == TO_LIM) begin
                    val_n = 1'b1;
                    tmo_n = 1'b1;
                    res_n = tick_q;
                    st_n  = MS_IDLE;
                end else begin
                    tick_n = tick_q + ONE;
                end
            end
            default: st_n = MS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= MS_IDLE;
            tick_q <= '0;
        end else begin
            st_q   <= st_n;
            tick_q <= tick_n;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_valid   <= 1'b0;
            meas_ticks   <= '0;
            meas_timeout <= 1'b0;
        end else begin
            meas_valid   <= val_n;
            meas_ticks   <= res_n;
            meas_timeout <= tmo_n;
        end
    end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import pll_lockdet_pkg::*;
#(
    parameter int MW            = 6,
    parameter int LOCK_NARROW   = 4,
    parameter int UNLOCK_NARROW = 8,
    parameter int LOCK_WIDE     = 8,
    parameter int UNLOCK_WIDE   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [MW-1:0]    meas_ticks,
    input  logic             meas_timeout,
    input  logic             win_sel,
    input  logic [1:0]       cnt_sel,
    output logic             lock,
    output logic [RUN_W-1:0] run_cnt
);
    localparam logic [MW-1:0] LN = MW'(LOCK_NARROW);
    localparam logic [MW-1:0] UN = MW'(UNLOCK_NARROW);
    localparam logic [MW-1:0] LW = MW'(LOCK_WIDE);
    localparam logic [MW-1:0] UW = MW'(UNLOCK_WIDE);

    lock_state_t      st_q, st_n;
    logic [RUN_W-1:0] run_n, run_inc;
    logic [MW-1:0]    lock_thr, unlock_thr;
    logic             is_good, is_bad;

    assign lock_thr   = win_sel ? LW : LN;
    assign unlock_thr = win_sel ? UW : UN;
    assign is_good    = !meas_timeout && (meas_ticks < lock_thr);
    assign is_bad     = meas_timeout || (meas_ticks > unlock_thr);
    assign run_inc    = run_cnt + RUN_W'(1);

    always_comb begin
        st_n  = st_q;
        run_n = run_cnt;
        unique case (st_q)
            LS_HUNT: begin
                if (meas_valid) begin
                    if (!is_good) begin
                        run_n = '0;
                    end else if (run_inc >= run_target(cnt_sel)) begin
                        st_n  = LS_LOCKED;
                        run_n = '0;
                    end else begin
                        run_n = run_inc;
                    end
                end
            end
            LS_LOCKED: begin
                if (meas_valid && is_bad) begin
                    st_n  = LS_HUNT;
                    run_n = '0;
                end
            end
            default: st_n = LS_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= LS_HUNT;
            run_cnt <= '0;
        end else begin
            st_q    <= st_n;
            run_cnt <= run_n;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock <= 1'b0;
        else        lock <= (st_n == LS_LOCKED);
    end
endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch
    import pll_lockdet_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 40,
    parameter int LOCK_NARROW   = 4,
    parameter int UNLOCK_NARROW = 8,
    parameter int LOCK_WIDE     = 8,
    parameter int UNLOCK_WIDE   = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic       win_sel,
    input  logic [1:0] cnt_sel,
    output logic       lock_o
);
    localparam int MW = $clog2(TIMEOUT_TICKS + 1);

    logic [1:0]       raw_in;
    logic [1:0]       rise;
    logic             meas_valid;
    logic [MW-1:0]    meas_ticks;
    logic             meas_timeout;
    logic [RUN_W-1:0] run_cnt;

    assign raw_in = {fb_in, ref_in};

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_sync
            edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (raw_in[k]),
                .rise     (rise[k])
            );
        end
    endgenerate

    skew_meter #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .MW(MW)) i_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_rise     (rise[0]),
        .fb_rise      (rise[1]),
        .meas_valid   (meas_valid),
        .meas_ticks   (meas_ticks),
        .meas_timeout (meas_timeout)
    );

    lock_fsm #(
        .MW            (MW),
        .LOCK_NARROW   (LOCK_NARROW),
        .UNLOCK_NARROW (UNLOCK_NARROW),
        .LOCK_WIDE     (LOCK_WIDE),
        .UNLOCK_WIDE   (UNLOCK_WIDE)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_valid   (meas_valid),
        .meas_ticks   (meas_ticks),
        .meas_timeout (meas_timeout),
        .win_sel      (win_sel),
        .cnt_sel      (cnt_sel),
        .lock         (lock_o),
        .run_cnt      (run_cnt)
    );
endmodule

// File: rtl/lock_watch_checker.sv
module lock_watch_checker #(
    parameter int TIMEOUT_TICKS = 40,
    parameter int LOCK_NARROW   = 4,
    parameter int UNLOCK_NARROW = 8,
    parameter int LOCK_WIDE     = 8,
    parameter int UNLOCK_WIDE   = 16,
    parameter int MW            = $clog2(TIMEOUT_TICKS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lock,
    input logic          meas_valid,
    input logic [MW-1:0] meas_ticks,
    input logic          meas_timeout,
    input logic [7:0]    run_cnt,
    input logic          win_sel
);
    int lthr, uthr;
    assign lthr = win_sel ? LOCK_WIDE : LOCK_NARROW;
    assign uthr = win_sel ? UNLOCK_WIDE : UNLOCK_NARROW;

    // R1: leaving reset, lock is low and the run is empty
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lock && run_cnt == 8'd0));

    // R10: lock only rises right after a result
    p_rise_after_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(meas_valid));

    // R7: a fall of lock needs a result beyond the unlock window
    p_fall_needs_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> ($past(meas_valid) &&
                         ($past(meas_timeout) || int'($past(meas_ticks)) > $past(uthr))));

    // R6: a result inside the unlock window keeps lock
    p_mid_band_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && meas_valid && !meas_timeout && int'(meas_ticks) <= uthr) |=> lock);

    // R5: a non-good result while hunting empties the run
    p_run_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && meas_valid && (meas_timeout || int'(meas_ticks) >= lthr))
            |=> (run_cnt == 8'd0 && !lock));

    // R9: a measured result never exceeds the timeout
    p_ticks_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> int'(meas_ticks) <= TIMEOUT_TICKS);
endmodule

bind pll_lock_watch lock_watch_checker #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .LOCK_NARROW   (LOCK_NARROW),
    .UNLOCK_NARROW (UNLOCK_NARROW),
    .LOCK_WIDE     (LOCK_WIDE),
    .UNLOCK_WIDE   (UNLOCK_WIDE)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock         (lock_o),
    .meas_valid   (meas_valid),
    .meas_ticks   (meas_ticks),
    .meas_timeout (meas_timeout),
    .run_cnt      (run_cnt),
    .win_sel      (win_sel)
);

// File: tb/test_pll_lock_watch.sv
module test_pll_lock_watch;
    localparam int TO = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       win_sel = 1'b0;
    logic [1:0] cnt_sel = 2'd0;
    logic       lock_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  exp_lock = 1'b0;
    int  exp_run = 0;

    always #10 clk = ~clk;   // 50 MHz

    pll_lock_watch i_pll_lock_watch (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .win_sel(win_sel), .cnt_sel(cnt_sel), .lock_o(lock_o)
    );

    function automatic int target_of(input logic [1:0] s);
        case (s)
            2'd0: return 5;
            2'd1: return 16;
            2'd2: return 64;
            default: return 255;
        endcase
    endfunction

    // 0 good, 1 neutral, 2 bad
    function automatic int classify(input int d, input bit miss, input bit ws);
        int lt, ut;
        lt = ws ? 8 : 4;
        ut = ws ? 16 : 8;
        if (miss)   return 2;
        if (d < lt) return 0;
        if (d > ut) return 2;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model(input int cls);
        if (!exp_lock) begin
            if (cls == 0) begin
                exp_run++;
                if (exp_run >= target_of(cnt_sel)) begin
                    exp_lock = 1'b1;
                    exp_run  = 0;
                end
            end else begin
                exp_run = 0;
            end
        end else if (cls == 2) begin
            exp_lock = 1'b0;
            exp_run  = 0;
        end
    endtask

    // One comparison cycle: d ticks between edges, fb leading if fb_first
    task automatic pfd_cycle(input int d, input bit fb_first, input bit miss);
        @(negedge clk);
        if (miss) begin
            if (fb_first) fb_in = 1'b1; else ref_in = 1'b1;
            repeat (TO + 8) @(negedge clk);
        end else if (d == 0) begin
            ref_in = 1'b1; fb_in = 1'b1;
            repeat (4) @(negedge clk);
        end else begin
            if (fb_first) fb_in = 1'b1; else ref_in = 1'b1;
            repeat (d) @(negedge clk);
            if (fb_first) ref_in = 1'b1; else fb_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (12) @(negedge clk);
        model(classify(d, miss, win_sel));
    endtask

    task automatic cyc_chk(input int d, input bit fb_first, input bit miss, input string req);
        pfd_cycle(d, fb_first, miss);
        chk(lock_o == exp_lock, req, lock_o, exp_lock);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_lock = 1'b0; exp_run = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic good_run(input int n, input string req);
        for (int i = 0; i < n; i++) pfd_cycle(i % 4, i[0], 1'b0);
        chk(lock_o == exp_lock, req, lock_o, exp_lock);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd7719);
        do_reset();
        chk(lock_o == 1'b0, "R1 reset", lock_o, 0);

        // R3/R4: setting 0 needs five good cycles
        good_run(4, "R3 four of five");
        chk(lock_o == 1'b0, "R3 not yet", lock_o, 0);
        cyc_chk(3, 1'b0, 1'b0, "R3 fifth good locks");
        chk(lock_o == 1'b1, "R4 count 5", lock_o, 1);

        // R6 neutral band with fb leading (R2), inclusive unlock edge
        cyc_chk(4, 1'b1, 1'b0, "R6 skew at lock thr");
        cyc_chk(8, 1'b0, 1'b0, "R6 skew at unlock thr");
        cyc_chk(6, 1'b1, 1'b0, "R2 fb leads mid band");
        chk(lock_o == 1'b1, "R6 still locked", lock_o, 1);

        // R7 one bad cycle drops lock
        cyc_chk(9, 1'b1, 1'b0, "R7 skew above unlock");
        chk(lock_o == 1'b0, "R7 dropped", lock_o, 0);

        // R5 borderline cycle clears run
        good_run(4, "R5 partial run");
        cyc_chk(4, 1'b0, 1'b0, "R5 skew equals lock thr");
        good_run(4, "R5 run restarted");
        chk(lock_o == 1'b0, "R5 no lock after clear", lock_o, 0);
        cyc_chk(0, 1'b0, 1'b0, "R2 simultaneous edges good");
        chk(lock_o == 1'b1, "R5 lock after full run", lock_o, 1);

        // R9 timeout while locked
        cyc_chk(0, 1'b1, 1'b1, "R9 missing edge");
        chk(lock_o == 1'b0, "R9 timeout drops", lock_o, 0);

        // R8 wide windows
        win_sel = 1'b1;
        for (int i = 0; i < 5; i++) cyc_chk(7, i[0], 1'b0, "R8 wide skew 7 good");
        chk(lock_o == 1'b1, "R8 wide lock", lock_o, 1);
        cyc_chk(16, 1'b0, 1'b0, "R8 wide skew 16 holds");
        cyc_chk(17, 1'b1, 1'b0, "R8 wide skew 17 drops");
        chk(lock_o == 1'b0, "R8 wide dropped", lock_o, 0);
        win_sel = 1'b0;

        // R1 reset mid-run
        good_run(3, "R1 pre-reset run");
        do_reset();
        good_run(4, "R1 run restarts after reset");
        chk(lock_o == 1'b0, "R1 cleared run", lock_o, 0);

        // R4 other count settings
        for (int s = 1; s < 4; s++) begin
            do_reset();
            cnt_sel = s[1:0];
            good_run(target_of(cnt_sel) - 1, "R4 one short");
            chk(lock_o == 1'b0, "R4 one short unlocked", lock_o, 0);
            cyc_chk(1, 1'b1, 1'b0, "R4 final good locks");
            chk(lock_o == 1'b1, "R4 count reached", lock_o, 1);
        end

        // Random cycles against the model
        do_reset();
        for (int blk = 0; blk < 4; blk++) begin
            cnt_sel = (blk % 2 == 0) ? 2'd0 : 2'd1;
            for (int i = 0; i < 80; i++) begin
                int d;
                bit miss;
                win_sel = ($urandom % 4) == 0;
                miss    = ($urandom % 20) == 0;
                d       = ($urandom % 3 != 0) ? int'($urandom % 5) : int'($urandom % 21);
                cyc_chk(d, $urandom % 2, miss, "R3 R6 R7 R9 random");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule